// File: doc/BRIEF.md
# Hash Engine Control Register Block

This block is the register front end of a hash accelerator. Software programs it over a 32-bit register interface. It writes a source address, a destination address, a key buffer address and a source length, and then writes a command word. Each stored word is trimmed to the bits that hardware honours. The command word is decoded into an algorithm code, a scatter-gather flag and an accumulative flag. A command with a legal encoding launches the engine through a one-cycle start pulse. A command with an illegal encoding launches nothing and is flagged instead.

When the engine reports done, the block sets a sticky completion flag in its status word. It does this whether or not interrupts were requested. The interrupt line is a level signal. It rises on completion only if the launching command asked for it. Software clears the flag and the line together by writing a one to the flag position. The hash datapath and all memory traffic sit outside this block.

Top module: `hashctl_regs`

## Requirements
- R1: After a synchronous reset, every register reads zero, and `irq`, `eng_start` and `cmd_bad` are low.
- R2: Registers sit at byte offsets 0x10 (crypt command, all 32 bits kept), 0x1C (status), 0x20 (source, keeps bits 30:0), 0x24 (destination, keeps bits 30:3), 0x28 (key buffer, keeps bits 30:3), 0x2C (length, keeps bits 27:0) and 0x30 (command, keeps mask 0x00147FFF). `word_addr` is the byte offset divided by four. Read data appears on `rdata` one cycle after `rd_en`.
- R3: A word address at or beyond 16 (byte offset 0x40 and up) reads as zero and ignores writes.
- R4: The command family field is bits 6:4 and the SHA-512 variant field is bits 12:10. The legal pairs (variant, family) and the resulting `eng_alg` codes are:
  - (000,000) MD5 = 0
  - (000,010) SHA-1 = 1
  - (000,100) SHA-224 = 2
  - (000,101) SHA-256 = 3
  - (000,011) SHA-512 = 5
  - (001,011) SHA-384 = 4
  - (010,011) SHA-256 = 3
  - (011,011) SHA-224 = 2
- R5: Any other (variant, family) pair starts no operation. It raises `cmd_bad` for exactly one cycle, one cycle after the command write.
- R6: A legal command written while idle raises `eng_start` for exactly one cycle, starting the cycle after the write. At that point `eng_sg` equals command bit 18, and `eng_accum` is high only when command bits 8:7 equal 10.
- R7: While an operation is outstanding, `eng_alg`, `eng_sg` and `eng_accum` hold steady. A command write in that period is neither stored nor started.
- R8: `eng_done` during an outstanding operation sets status bit 9, whatever the value of command bit 9.
- R9: `irq` rises on completion only when bit 9 of the launching command was set.
- R10: Writing status with bit 9 set clears the flag and drops `irq`. Writing status with bit 9 clear leaves both unchanged.
- R11: `eng_done` while no operation is outstanding has no effect on the status word or on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| word_addr | input | 10 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src_addr | output | 32 | Masked source address |
| dst_addr | output | 32 | Masked destination address |
| key_addr | output | 32 | Masked key buffer address |
| src_len | output | 32 | Masked source length |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_alg | output | 3 | Decoded algorithm code |
| eng_sg | output | 1 | Scatter-gather enable for the operation |
| eng_accum | output | 1 | Accumulative mode for the operation |
| eng_done | input | 1 | Completion from the engine |
| cmd_bad | output | 1 | One-cycle flag for an illegal command word |
| irq | output | 1 | Level interrupt |

## Verification
Every result of this block is one register stage away from its cause:
- Read data is due in the cycle after the read strobe.
- `eng_start`, `cmd_bad` and the engine fields are due in the cycle after the command write.
- The status flag and `irq` are due in the cycle after `eng_done` or after a status write.

The bench drives every stimulus on a falling edge and holds it across exactly one rising edge. It then samples at the next falling edge, which lands on the cycle in which each of these results is first valid. For the one-cycle start pulse, a further sample one cycle later confirms that the pulse has ended.

// File: rtl/hashctl_pkg.sv
package hashctl_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hash_alg_e;

  typedef struct packed {
    logic      legal;
    hash_alg_e alg;
    logic      sg;
    logic      accum;
    logic      irq_en;
  } cmd_dec_t;

  // Command word field positions (decoded by the launch path)
  localparam int FAM_LSB  = 4;
  localparam int FAM_W    = 3;
  localparam int VAR_LSB  = 10;
  localparam int VAR_W    = 3;
  localparam int MODE_LSB = 7;
  localparam int MODE_W   = 2;
  localparam int IE_BIT   = 9;
  localparam int SG_BIT   = 18;
  localparam logic [MODE_W-1:0] MODE_ACCUM = 2'b10;

  // Status flag position
  localparam int DONE_BIT = 9;

  // Word indices (byte offset / 4)
  localparam int IDX_CRYPT  = 4;
  localparam int IDX_STATUS = 7;
  localparam int IDX_SRC    = 8;
  localparam int IDX_DST    = 9;
  localparam int IDX_KEY    = 10;
  localparam int IDX_LEN    = 11;
  localparam int IDX_CMD    = 12;

endpackage

// File: rtl/hashctl_cmd_decode.sv
module hashctl_cmd_decode
  import hashctl_pkg::*;
(
  input  logic [FAM_W-1:0]  fam,
  input  logic [VAR_W-1:0]  vsel,
  input  logic [MODE_W-1:0] mode,
  input  logic              ie,
  input  logic              sg,
  output cmd_dec_t          dec
);

  always_comb begin
    dec.legal  = 1'b1;
    dec.alg    = ALG_MD5;
    dec.sg     = sg;
    dec.accum  = (mode == MODE_ACCUM);
    dec.irq_en = ie;
    case (fam)
      3'b000: dec.alg = ALG_MD5;
      3'b010: dec.alg = ALG_SHA1;
      3'b100: dec.alg = ALG_SHA224;
      3'b101: dec.alg = ALG_SHA256;
      3'b011: begin
        case (vsel)
          3'b000:  dec.alg = ALG_SHA512;
          3'b001:  dec.alg = ALG_SHA384;
          3'b010:  dec.alg = ALG_SHA256;
          3'b011:  dec.alg = ALG_SHA224;
          default: dec.legal = 1'b0;
        endcase
      end
      default: dec.legal = 1'b0;
    endcase
    // Variant bits are only meaningful for the wide family
    if (fam != 3'b011 && vsel != '0) dec.legal = 1'b0;
  end

endmodule

// File: rtl/hashctl_launch.sv
module hashctl_launch
  import hashctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmd_wr,
  input  cmd_dec_t  dec,
  input  logic      eng_done,
  output logic      eng_start,
  output hash_alg_e eng_alg,
  output logic      eng_sg,
  output logic      eng_accum,
  output logic      busy,
  output logic      bad_cmd,
  output logic      done_evt,
  output logic      done_ie
);

  assign done_evt = busy & eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      eng_start <= 1'b0;
      eng_alg   <= ALG_MD5;
      eng_sg    <= 1'b0;
      eng_accum <= 1'b0;
      busy      <= 1'b0;
      bad_cmd   <= 1'b0;
      done_ie   <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      bad_cmd   <= 1'b0;
      if (done_evt) busy <= 1'b0;
      if (cmd_wr && !busy) begin
        if (dec.legal) begin
          eng_start <= 1'b1;
          busy      <= 1'b1;
          eng_alg   <= dec.alg;
          eng_sg    <= dec.sg;
          eng_accum <= dec.accum;
          done_ie   <= dec.irq_en;
        end else begin
          bad_cmd   <= 1'b1;
        end
      end
    end
  end

  // R6: launch pulse lasts a single cycle
  a_r6_start_single: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  // R5: a rejected command never coincides with a launch
  a_r5_bad_no_start: assert property (@(posedge clk) disable iff (rst)
    bad_cmd |-> !eng_start);

  // R7: engine fields frozen while an operation is outstanding
  a_r7_hold_fields: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> ($stable(eng_alg) && $stable(eng_sg) && $stable(eng_accum)));

  // R7: a command written while busy launches nothing
  a_r7_busy_no_launch: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done && cmd_wr) |=> !eng_start);

endmodule

// File: rtl/hashctl_irq.sv
module hashctl_irq (
  input  logic clk,
  input  logic rst,
  input  logic done_evt,
  input  logic ie,
  input  logic clr,
  output logic flag,
  output logic irq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else if (done_evt) begin
      flag <= 1'b1;
      irq  <= irq | ie;
    end else if (clr) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end
  end

  // R9: the line is never high without the sticky flag
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

  // R8: completion always sets the flag
  a_r8_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> flag);

  // R10: clear request drops flag and line
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !done_evt) |=> (!flag && !irq));

endmodule

// File: rtl/hashctl_regs.sv
module hashctl_regs
  import hashctl_pkg::*;
#(
  parameter int          WADDR_W  = 10,
  parameter int          NREGS    = 16,
  parameter int          LEN_BITS = 28,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] KEY_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WADDR_W-1:0] word_addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [31:0]        src_addr,
  output logic [31:0]        dst_addr,
  output logic [31:0]        key_addr,
  output logic [31:0]        src_len,
  output logic               eng_start,
  output logic [2:0]         eng_alg,
  output logic               eng_sg,
  output logic               eng_accum,
  input  logic               eng_done,
  output logic               cmd_bad,
  output logic               irq
);

  localparam int          IDX_W    = $clog2(NREGS);
  localparam logic [31:0] LEN_MASK = 32'((64'd1 << LEN_BITS) - 64'd1);

  function automatic logic [31:0] word_mask(int idx);
    case (idx)
      IDX_STATUS: return 32'h0;
      IDX_SRC:    return SRC_MASK;
      IDX_DST:    return DST_MASK;
      IDX_KEY:    return KEY_MASK;
      IDX_LEN:    return LEN_MASK;
      IDX_CMD:    return CMD_MASK;
      default:    return 32'hFFFF_FFFF;
    endcase
  endfunction

  logic [31:0]      regs [NREGS];
  logic [IDX_W-1:0] idx;
  logic             in_range;
  logic [NREGS-1:0] wr_hit;
  logic             busy;
  logic             cmd_wr;
  logic             status_clr;
  logic             done_evt;
  logic             done_ie;
  logic             flag;
  logic [31:0]      cmd_in;
  logic [31:0]      status_word;
  cmd_dec_t         dec;
  hash_alg_e        alg_q;

  assign idx      = word_addr[IDX_W-1:0];
  assign in_range = (int'(word_addr) < NREGS);
  assign cmd_wr   = wr_en && in_range && (int'(idx) == IDX_CMD);
  assign status_clr = wr_en && in_range && (int'(idx) == IDX_STATUS) && wdata[DONE_BIT];
  assign cmd_in   = wdata & CMD_MASK;
  assign status_word = 32'(flag) << DONE_BIT;

  for (genvar g = 0; g < NREGS; g++) begin : g_hit
    if (g == IDX_CMD) begin : g_cmd
      assign wr_hit[g] = wr_en && in_range && (int'(idx) == g) && !busy;
    end else begin : g_plain
      assign wr_hit[g] = wr_en && in_range && (int'(idx) == g);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NREGS; i++)
        if (wr_hit[i]) regs[i] <= wdata & word_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (!in_range)                        rdata <= '0;
      else if (int'(idx) == IDX_STATUS)     rdata <= status_word;
      else                                  rdata <= regs[idx];
    end
  end

  assign src_addr = regs[IDX_SRC];
  assign dst_addr = regs[IDX_DST];
  assign key_addr = regs[IDX_KEY];
  assign src_len  = regs[IDX_LEN];

  hashctl_cmd_decode u_dec (
    .fam  (cmd_in[FAM_LSB +: FAM_W]),
    .vsel (cmd_in[VAR_LSB +: VAR_W]),
    .mode (cmd_in[MODE_LSB +: MODE_W]),
    .ie   (cmd_in[IE_BIT]),
    .sg   (cmd_in[SG_BIT]),
    .dec  (dec)
  );

  hashctl_launch u_launch (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .dec       (dec),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_alg   (alg_q),
    .eng_sg    (eng_sg),
    .eng_accum (eng_accum),
    .busy      (busy),
    .bad_cmd   (cmd_bad),
    .done_evt  (done_evt),
    .done_ie   (done_ie)
  );

  assign eng_alg = alg_q;

  hashctl_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .done_evt (done_evt),
    .ie       (done_ie),
    .clr      (status_clr),
    .flag     (flag),
    .irq      (irq)
  );

  // R3: an out-of-range read returns zero
  a_r3_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_range) |=> (rdata == 32'h0));

  // R7: command register untouched by a write while busy
  a_r7_cmd_kept_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && busy) |=> $stable(regs[IDX_CMD]));

  // R2: length register never holds bits above its width
  a_r2_len_width: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_hit[IDX_LEN]) |=> ((src_len & ~LEN_MASK) == 32'h0));

endmodule

// File: tb/hashctl_regs_tb.sv
module hashctl_regs_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  // {cmd[31:0], legal, alg[2:0], sg, accum, ie}
  localparam logic [38:0] VEC [NVEC] = '{
    {32'h0000_0000, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0000_0020, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0},
    {32'h0000_0040, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
    {32'h0000_0050, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
    {32'h0000_0030, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0},
    {32'h0000_0430, 1'b1, 3'd4, 1'b0, 1'b0, 1'b0},
    {32'h0000_0830, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0},
    {32'h0000_0C30, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0},
    {32'h0000_0060, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0000_0070, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0000_0010, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0000_0420, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0000_1030, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h0004_0150, 1'b1, 3'd3, 1'b1, 1'b1, 1'b0},
    {32'h0000_0230, 1'b1, 3'd5, 1'b0, 1'b0, 1'b1},
    {32'h0000_0180, 1'b1, 3'd0, 1'b0, 1'b0, 1'b0},
    {32'h8000_0030, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0},
    {32'h0000_0250, 1'b1, 3'd3, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  word_addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, src_addr, dst_addr, key_addr, src_len;
  logic        eng_start, eng_sg, eng_accum, cmd_bad, irq;
  logic [2:0]  eng_alg;
  logic        eng_done = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hashctl_regs u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .word_addr(word_addr),
    .wdata(wdata), .rdata(rdata), .src_addr(src_addr), .dst_addr(dst_addr),
    .key_addr(key_addr), .src_len(src_len), .eng_start(eng_start),
    .eng_alg(eng_alg), .eng_sg(eng_sg), .eng_accum(eng_accum),
    .eng_done(eng_done), .cmd_bad(cmd_bad), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; word_addr = 10'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; word_addr = 10'(a);
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    bus_rd(7, rd);  check("R1 status", rd, 32'h0);
    bus_rd(8, rd);  check("R1 src", rd, 32'h0);
    bus_rd(12, rd); check("R1 cmd", rd, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 start", 32'(eng_start), 32'h0);
    check("R1 bad", 32'(cmd_bad), 32'h0);

    // Table walk: R4 R5 R6 R8 R9 R10 R11
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] c;
      logic        lg, sg, ac, ie;
      logic [2:0]  al;
      c  = VEC[i][38:7];
      lg = VEC[i][6];
      al = VEC[i][5:3];
      sg = VEC[i][2];
      ac = VEC[i][1];
      ie = VEC[i][0];
      bus_wr(12, c);
      check($sformatf("R6 vec%0d start", i), 32'(eng_start), 32'(lg));
      check($sformatf("R5 vec%0d bad", i), 32'(cmd_bad), 32'(!lg));
      if (lg) begin
        check($sformatf("R4 vec%0d alg", i), 32'(eng_alg), 32'(al));
        check($sformatf("R6 vec%0d sg", i), 32'(eng_sg), 32'(sg));
        check($sformatf("R6 vec%0d accum", i), 32'(eng_accum), 32'(ac));
        @(negedge clk);
        check($sformatf("R6 vec%0d start ends", i), 32'(eng_start), 32'h0);
      end else begin
        @(negedge clk);
        check($sformatf("R5 vec%0d bad ends", i), 32'(cmd_bad), 32'h0);
      end
      bus_rd(12, rd);
      check($sformatf("R2 vec%0d cmd mask", i), rd, c & 32'h0014_7FFF);
      pulse_done();
      if (lg) begin
        check($sformatf("R9 vec%0d irq", i), 32'(irq), 32'(ie));
        bus_rd(7, rd);
        check($sformatf("R8 vec%0d status", i), rd, 32'h200);
        bus_wr(7, 32'h200);
        check($sformatf("R10 vec%0d irq cleared", i), 32'(irq), 32'h0);
        bus_rd(7, rd);
        check($sformatf("R10 vec%0d status cleared", i), rd, 32'h0);
      end else begin
        bus_rd(7, rd);
        check($sformatf("R11 vec%0d idle done", i), rd, 32'h0);
        check($sformatf("R11 vec%0d idle irq", i), 32'(irq), 32'h0);
      end
    end

    // R2: masks on address and length registers
    bus_wr(8, 32'hFFFF_FFFF);  check("R2 src port", src_addr, 32'h7FFF_FFFF);
    bus_wr(9, 32'hFFFF_FFFF);  check("R2 dst port", dst_addr, 32'h7FFF_FFF8);
    bus_wr(10, 32'hFFFF_FFFF); check("R2 key port", key_addr, 32'h7FFF_FFF8);
    bus_wr(11, 32'hFFFF_FFFF); check("R2 len port", src_len, 32'h0FFF_FFFF);
    bus_rd(9, rd);  check("R2 dst read", rd, 32'h7FFF_FFF8);
    bus_rd(11, rd); check("R2 len read", rd, 32'h0FFF_FFFF);
    bus_wr(4, 32'hDEAD_BEEF);
    bus_rd(4, rd);  check("R2 crypt read", rd, 32'hDEAD_BEEF);

    // R3: out-of-range offsets
    bus_wr(16, 32'h1234_5678);
    bus_rd(16, rd);  check("R3 oob 0x40", rd, 32'h0);
    bus_wr(700, 32'hFFFF_FFFF);
    bus_rd(700, rd); check("R3 oob far", rd, 32'h0);
    bus_rd(8, rd);   check("R3 src untouched", rd, 32'h7FFF_FFFF);

    // R7: command while busy is ignored, fields held
    bus_wr(12, 32'h0004_0350);
    check("R7 launch", 32'(eng_start), 32'h1);
    bus_wr(12, 32'h0000_0020);
    check("R7 no second start", 32'(eng_start), 32'h0);
    check("R7 no bad", 32'(cmd_bad), 32'h0);
    check("R7 alg held", 32'(eng_alg), 32'd3);
    check("R7 sg held", 32'(eng_sg), 32'h1);
    check("R7 accum held", 32'(eng_accum), 32'h1);
    bus_rd(12, rd); check("R7 cmd not stored", rd, 32'h0004_0350);
    pulse_done();
    check("R9 irq set", 32'(irq), 32'h1);

    // R10: writing zero to the flag leaves it
    bus_wr(7, 32'h0);
    bus_rd(7, rd);  check("R10 w0 keeps flag", rd, 32'h200);
    check("R10 w0 keeps irq", 32'(irq), 32'h1);
    bus_wr(7, 32'hFFFF_FFFF);
    bus_rd(7, rd);  check("R10 w1 clears", rd, 32'h0);
    check("R10 irq low", 32'(irq), 32'h0);

    // R11: done with nothing outstanding
    pulse_done();
    bus_rd(7, rd);  check("R11 status idle", rd, 32'h0);
    check("R11 irq idle", 32'(irq), 32'h0);

    // R1: reset in mid-operation
    bus_wr(12, 32'h0000_0230);
    @(negedge clk); rst = 1'b1;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    bus_rd(12, rd); check("R1 cmd after reset", rd, 32'h0);
    check("R1 start after reset", 32'(eng_start), 32'h0);
    pulse_done();
    bus_rd(7, rd);  check("R1 idle after reset", rd, 32'h0);

    finish_run();
  end

endmodule